// File: doc/BRIEF.md
# Receive Lane Framing Rule Checker

This block sits on the receive side of a multi-lane serial link. It sits after lane de-skew and before packet reassembly. Each clock it sees one decoded symbol per lane, each with a flag that tells control symbols from data symbols. It checks where the framing symbols fall across the lanes: packet start, packet end, end-bad and PAD. It also checks that comma-led ordered sets and logical idle fill every active lane of a cycle. The symbol contents of a packet are never inspected.

The checker keeps a small link state: idle, inside a packet, or in a gap after a packet closed. With this state it can tell the first start after idle from a back-to-back start. Any cycle with at least one violation produces a one-cycle receiver-error pulse towards the data link layer. The class of the violation is also recorded in a sticky status vector, which holds until a clear pulse arrives. The configured link width selects how many low-numbered lanes are active, and all other lanes are ignored.

Top module: `lane_frame_checker`

## Requirements
- R1: While reset is asserted and after it is released, `rx_err_o` is low, `err_sticky_o` is zero and the link state is idle.
- R2: A start symbol is a control symbol 8'hFB or 8'h5C. If no packet is open, and the link was idle with no end symbol earlier in the same cycle, the start must be on lane 0. Any other start with no packet open must be on a lane whose index is a multiple of 4. A violation sets sticky bit 0.
- R3: An end symbol is a control symbol 8'hFD or 8'hFE. When it closes an open packet, its lane index modulo 4 must equal 3. A violation sets sticky bit 1.
- R4: A start while a packet is open, or an end symbol while no packet is open, is an order violation and sets sticky bit 2. Its lane position is not judged.
- R5: A PAD is a control symbol 8'hF7. It is legal only outside a packet, on a lane above an end symbol in the same cycle. Otherwise it sets sticky bit 3.
- R6: A comma is a control symbol 8'hBC. A comma on some but not all active lanes of a cycle sets sticky bit 4. A comma on all active lanes is legal.
- R7: Any data symbol outside a packet counts as logical idle. If it appears on some but not all active lanes of a cycle, sticky bit 5 is set.
- R8: Width codes 0, 1, 2 and 3 select 4, 8, 16 and 16 active lanes, capped at the lane count. Symbols on lanes above the active count have no effect.
- R9: `rx_err_o` is high for exactly the cycle after each cycle with at least one violation, and low otherwise.
- R10: Sticky bits hold until `sticky_clr_i` is high. A clear drops the old bits, but violations in the clearing cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_width_i | input | 2 | Width code selecting the active lanes |
| lane_sym_i | input | LANES*8 | One symbol per lane, lane n in bits [8n+7:8n] |
| lane_k_i | input | LANES | Per-lane control-symbol flag |
| sticky_clr_i | input | 1 | Clears the sticky status |
| rx_err_o | output | 1 | Receiver-error pulse, one cycle per offending cycle |
| err_sticky_o | output | 6 | Sticky violation classes (bit map in R2 to R7) |

## Verification
The assertions assume that the width code changes only while reset is held, and that symbols and flags are known on every clock after reset. The bench sets the width inside its reset task and drives every lane on every cycle. Ordered-set bodies are sent as the same control symbol on all lanes, so they stay outside every rule, as they would on a real link. Some offending patterns unavoidably break two rules at once, such as a late first start next to idle lanes. For those, the bench expects both sticky bits instead of assuming that one class masks the other.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;

  localparam int SYM_W = 8;

  localparam logic [SYM_W-1:0] SYM_COMMA = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_TLP_START = 8'hFB;
  localparam logic [SYM_W-1:0] SYM_DLLP_START = 8'h5C;
  localparam logic [SYM_W-1:0] SYM_GOOD_END = 8'hFD;
  localparam logic [SYM_W-1:0] SYM_BAD_END = 8'hFE;
  localparam logic [SYM_W-1:0] SYM_FILL = 8'hF7;

  localparam int ERR_BITS = 6;
  localparam int E_START = 0;
  localparam int E_END = 1;
  localparam int E_ORDER = 2;
  localparam int E_PAD = 3;
  localparam int E_COMMA = 4;
  localparam int E_IDLE = 5;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_PKT = 2'd1,
    LS_GAP = 2'd2
  } link_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic fill;
    logic comma;
    logic data;
  } lane_cls_t;

  // Number of active lanes for a width code: base lanes doubled per step.
  function automatic int lanes_for_code(input logic [1:0] code, input int base,
                                        input int max_lanes);
    int n;
    n = base << code;
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

  // Start lane rule: the first start after idle needs lane 0; others need a group boundary.
  function automatic logic start_pos_ok(input int lane, input int group, input logic from_idle);
    if (from_idle) return lane == 0;
    return (lane % group) == 0;
  endfunction

  // End lane rule: the last lane of a lane group.
  function automatic logic end_pos_ok(input int lane, input int group);
    return (lane % group) == (group - 1);
  endfunction

endpackage

// File: rtl/lfc_lane_classify.sv
`timescale 1ns/1ps
module lfc_lane_classify
  import lfc_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [LANES*SYM_W-1:0] sym_i,
  input  logic [LANES-1:0]       k_i,
  input  logic [LANES-1:0]       act_i,
  output lane_cls_t [LANES-1:0]  cls_o
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [SYM_W-1:0] sym;
    logic             ctl;
    assign sym = sym_i[ln*SYM_W +: SYM_W];
    assign ctl = act_i[ln] & k_i[ln];

    assign cls_o[ln].start = ctl & ((sym == SYM_TLP_START) | (sym == SYM_DLLP_START));
    assign cls_o[ln].stop  = ctl & ((sym == SYM_GOOD_END) | (sym == SYM_BAD_END));
    assign cls_o[ln].fill  = ctl & (sym == SYM_FILL);
    assign cls_o[ln].comma = ctl & (sym == SYM_COMMA);
    assign cls_o[ln].data  = act_i[ln] & ~k_i[ln];
  end

endmodule

// File: rtl/lfc_position_scan.sv
`timescale 1ns/1ps
module lfc_position_scan
  import lfc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int GROUP = 4
) (
  input  lane_cls_t [LANES-1:0] cls_i,
  input  link_state_e           state_i,
  output logic                  start_err_o,
  output logic                  end_err_o,
  output logic                  order_err_o,
  output logic                  pad_err_o,
  output logic [LANES-1:0]      idle_mask_o,
  output link_state_e           state_o
);

  // Walk the lanes in order, carrying packet-open state from lane to lane.
  always_comb begin
    logic open_v;
    logic seen_end_v;
    open_v      = (state_i == LS_PKT);
    seen_end_v  = 1'b0;
    start_err_o = 1'b0;
    end_err_o   = 1'b0;
    order_err_o = 1'b0;
    pad_err_o   = 1'b0;
    idle_mask_o = '0;
    for (int ln = 0; ln < LANES; ln++) begin
      if (cls_i[ln].start) begin
        if (open_v) begin
          order_err_o = 1'b1;
        end else if (!start_pos_ok(ln, GROUP, (state_i == LS_IDLE) && !seen_end_v)) begin
          start_err_o = 1'b1;
        end
        open_v = 1'b1;
      end
      if (cls_i[ln].stop) begin
        if (!open_v) begin
          order_err_o = 1'b1;
        end else if (!end_pos_ok(ln, GROUP)) begin
          end_err_o = 1'b1;
        end
        open_v     = 1'b0;
        seen_end_v = 1'b1;
      end
      if (cls_i[ln].fill && (open_v || !seen_end_v)) begin
        pad_err_o = 1'b1;
      end
      if (cls_i[ln].data && !open_v) begin
        idle_mask_o[ln] = 1'b1;
      end
    end
    if (open_v) begin
      state_o = LS_PKT;
    end else if (|idle_mask_o) begin
      state_o = LS_IDLE;
    end else if (seen_end_v) begin
      state_o = LS_GAP;
    end else begin
      state_o = state_i;
    end
  end

endmodule

// File: rtl/lfc_uniform_check.sv
`timescale 1ns/1ps
module lfc_uniform_check #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] act_i,
  input  logic [LANES-1:0] idle_mask_i,
  input  logic [LANES-1:0] comma_mask_i,
  output logic             idle_mix_o,
  output logic             comma_mix_o
);

  function automatic logic partial(input logic [LANES-1:0] seen, input logic [LANES-1:0] act);
    return (seen != '0) && (seen != act);
  endfunction

  assign idle_mix_o  = partial(idle_mask_i, act_i);
  assign comma_mix_o = partial(comma_mask_i, act_i);

endmodule

// File: rtl/lfc_err_report.sv
`timescale 1ns/1ps
module lfc_err_report #(
  parameter int NBITS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [NBITS-1:0] viol_i,
  output logic             pulse_o,
  output logic [NBITS-1:0] sticky_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o  <= 1'b0;
      sticky_o <= '0;
    end else begin
      pulse_o  <= |viol_i;
      sticky_o <= (clr_i ? '0 : sticky_o) | viol_i;
    end
  end

endmodule

// File: rtl/lane_frame_checker.sv
`timescale 1ns/1ps
module lane_frame_checker
  import lfc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int GROUP = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             link_width_i,
  input  logic [LANES*SYM_W-1:0] lane_sym_i,
  input  logic [LANES-1:0]       lane_k_i,
  input  logic                   sticky_clr_i,
  output logic                   rx_err_o,
  output logic [ERR_BITS-1:0]    err_sticky_o
);

  logic [LANES-1:0]      act_mask_w;
  lane_cls_t [LANES-1:0] cls_w;
  logic [LANES-1:0]      idle_mask_w;
  logic [LANES-1:0]      com_mask_w;
  logic [ERR_BITS-1:0]   viol_w;
  link_state_e           state_q;
  link_state_e           state_d;
  logic                  start_err_w;
  logic                  end_err_w;
  logic                  order_err_w;
  logic                  pad_err_w;
  logic                  idle_mix_w;
  logic                  com_mix_w;

  always_comb begin
    int n_act;
    n_act = lanes_for_code(link_width_i, GROUP, LANES);
    for (int ln = 0; ln < LANES; ln++) begin
      act_mask_w[ln] = (ln < n_act);
    end
  end

  lfc_lane_classify #(.LANES(LANES)) u_classify (
    .sym_i (lane_sym_i),
    .k_i   (lane_k_i),
    .act_i (act_mask_w),
    .cls_o (cls_w)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_com
    assign com_mask_w[ln] = cls_w[ln].comma;
  end

  lfc_position_scan #(.LANES(LANES), .GROUP(GROUP)) u_scan (
    .cls_i       (cls_w),
    .state_i     (state_q),
    .start_err_o (start_err_w),
    .end_err_o   (end_err_w),
    .order_err_o (order_err_w),
    .pad_err_o   (pad_err_w),
    .idle_mask_o (idle_mask_w),
    .state_o     (state_d)
  );

  lfc_uniform_check #(.LANES(LANES)) u_uniform (
    .act_i        (act_mask_w),
    .idle_mask_i  (idle_mask_w),
    .comma_mask_i (com_mask_w),
    .idle_mix_o   (idle_mix_w),
    .comma_mix_o  (com_mix_w)
  );

  always_comb begin
    viol_w          = '0;
    viol_w[E_START] = start_err_w;
    viol_w[E_END]   = end_err_w;
    viol_w[E_ORDER] = order_err_w;
    viol_w[E_PAD]   = pad_err_w;
    viol_w[E_COMMA] = com_mix_w;
    viol_w[E_IDLE]  = idle_mix_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_IDLE;
    else         state_q <= state_d;
  end

  lfc_err_report #(.NBITS(ERR_BITS)) u_report (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sticky_clr_i),
    .viol_i   (viol_w),
    .pulse_o  (rx_err_o),
    .sticky_o (err_sticky_o)
  );

endmodule

// File: rtl/lfc_checker.sv
`timescale 1ns/1ps
module lfc_checker #(
  parameter int LANES = 16,
  parameter int NBITS = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       link_width_i,
  input logic             sticky_clr_i,
  input logic [NBITS-1:0] viol_w,
  input logic [LANES-1:0] idle_mask_w,
  input logic [LANES-1:0] com_mask_w,
  input logic [LANES-1:0] act_mask_w,
  input logic             rx_err_o,
  input logic [NBITS-1:0] err_sticky_o
);

  // R9: a pulse follows every offending cycle
  a_r9_pulse_after_violation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_w != '0) |=> rx_err_o);

  // R9: no pulse after a clean cycle
  a_r9_quiet_after_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_w == '0) |=> !rx_err_o);

  // R10: sticky bits only grow without a clear
  a_r10_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sticky_clr_i |=> ((err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o)));

  // R10: every violation class lands in the sticky vector
  a_r10_sticky_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_w != '0) |=> ((err_sticky_o & $past(viol_w)) == $past(viol_w)));

  // R6: comma on part of the active lanes is recorded
  a_r6_comma_partial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((com_mask_w != '0) && (com_mask_w != act_mask_w)) |=> err_sticky_o[4]);

  // R7: idle on part of the active lanes is recorded
  a_r7_idle_partial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idle_mask_w != '0) && (idle_mask_w != act_mask_w)) |=> err_sticky_o[5]);

  // R8: inactive lanes never contribute idle or comma
  a_r8_inactive_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idle_mask_w | com_mask_w) & ~act_mask_w) == '0);

  // R8: input assumption, width code changes only under reset
  a_r8_width_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(link_width_i));

endmodule

bind lane_frame_checker lfc_checker #(.LANES(LANES), .NBITS(lfc_pkg::ERR_BITS)) u_lfc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .link_width_i (link_width_i),
  .sticky_clr_i (sticky_clr_i),
  .viol_w       (viol_w),
  .idle_mask_w  (idle_mask_w),
  .com_mask_w   (com_mask_w),
  .act_mask_w   (act_mask_w),
  .rx_err_o     (rx_err_o),
  .err_sticky_o (err_sticky_o)
);

// File: tb/lane_frame_checker_bench.sv
`timescale 1ns/1ps
module lane_frame_checker_bench;
  localparam int LANES = 16;
  localparam logic [7:0] K_STP = 8'hFB, K_SDP = 8'h5C, K_END = 8'hFD, K_EDB = 8'hFE;
  localparam logic [7:0] K_PAD = 8'hF7, K_COM = 8'hBC, K_SKP = 8'h1C;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           width = 2'd0;
  logic [LANES*8-1:0]   sym_bus = '0;
  logic [LANES-1:0]     k_bus = '0;
  logic                 clr = 1'b0;
  logic                 err;
  logic [5:0]           sticky;
  int                   n_chk = 0;
  int                   n_fail = 0;
  logic [7:0]           s [LANES];
  logic                 kk [LANES];

  always #2.5 clk = ~clk;

  lane_frame_checker u_lane_frame_checker (
    .clk_i (clk), .rst_ni (rst_n), .link_width_i (width), .lane_sym_i (sym_bus),
    .lane_k_i (k_bus), .sticky_clr_i (clr), .rx_err_o (err), .err_sticky_o (sticky)
  );

  task automatic fill(input logic [7:0] v, input logic k);
    for (int i = 0; i < LANES; i++) begin s[i] = v; kk[i] = k; end
  endtask

  task automatic put(input int lane, input logic [7:0] v, input logic k);
    s[lane] = v; kk[lane] = k;
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic step();
    for (int i = 0; i < LANES; i++) begin sym_bus[i*8 +: 8] = s[i]; k_bus[i] = kk[i]; end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_err, input logic [5:0] exp_st);
    n_chk++;
    if (err !== exp_err || sticky !== exp_st) begin
      n_fail++;
      $display("FAIL %s: err=%b sticky=%b expected err=%b sticky=%b", req, err, sticky, exp_err, exp_st);
    end
  endtask

  task automatic restart(input logic [1:0] w);
    @(negedge clk);
    rst_n = 1'b0; width = w; clr = 1'b0; fill(8'h00, 1'b0);
    step(); step();
    rst_n = 1'b1;
  endtask

  // Open a packet: start on lane 0, data elsewhere.
  task automatic open_pkt();
    fill(8'h33, 1'b0); put(0, K_STP, 1'b1); step();
  endtask

  task automatic t_reset();
    restart(2'd1);
    chk("R1 reset state", 1'b0, 6'b000000);
    fill(8'h00, 1'b0); step();
    chk("R1 idle after reset", 1'b0, 6'b000000);
  endtask

  task automatic t_x4_legal();
    restart(2'd0);
    open_pkt(); chk("R2 x4 start lane 0", 1'b0, 6'b000000);
    fill(8'h44, 1'b0); step(); chk("R2 x4 packet body", 1'b0, 6'b000000);
    fill(8'h55, 1'b0); put(3, K_END, 1'b1); step(); chk("R3 x4 end lane 3", 1'b0, 6'b000000);
    fill(8'h00, 1'b0); step(); chk("R7 x4 full idle", 1'b0, 6'b000000);
    fill(8'h00, 1'b0); put(0, K_SDP, 1'b1); put(1, 8'h12, 1'b0); put(2, 8'h34, 1'b0);
    put(3, K_EDB, 1'b1); step(); chk("R2 R3 x4 short packet", 1'b0, 6'b000000);
  endtask

  task automatic t_x4_bad();
    restart(2'd0);
    fill(8'h00, 1'b0); put(1, K_STP, 1'b1); put(2, 8'h11, 1'b0); put(3, 8'h11, 1'b0); step();
    chk("R2 x4 start lane 1 (plus partial idle)", 1'b1, 6'b100001);
    restart(2'd0);
    open_pkt();
    fill(8'h66, 1'b0); put(2, K_END, 1'b1); put(3, K_PAD, 1'b1); step();
    chk("R3 x4 end lane 2", 1'b1, 6'b000010);
  endtask

  task automatic t_x8_starts();
    restart(2'd1);
    fill(8'h00, 1'b0); put(4, K_STP, 1'b1);
    for (int i = 5; i < 8; i++) put(i, 8'h21, 1'b0);
    step(); chk("R2 x8 first start off lane 0", 1'b1, 6'b100001);
    restart(2'd1);
    open_pkt();
    fill(8'h22, 1'b0); put(3, K_END, 1'b1); put(4, K_STP, 1'b1); step();
    chk("R2 x8 back-to-back lane 4", 1'b0, 6'b000000);
    fill(8'h23, 1'b0); put(7, K_EDB, 1'b1); step(); chk("R3 x8 end lane 7", 1'b0, 6'b000000);
    fill(8'h24, 1'b0); put(0, K_SDP, 1'b1); step(); chk("R2 x8 start after gap", 1'b0, 6'b000000);
    fill(8'h25, 1'b0); put(3, K_END, 1'b1); put(4, K_PAD, 1'b1); put(5, K_PAD, 1'b1);
    put(6, K_STP, 1'b1); step();
    chk("R2 x8 back-to-back lane 6", 1'b1, 6'b000001);
  endtask

  task automatic t_ends_wide();
    restart(2'd2);
    open_pkt();
    fill(8'h31, 1'b0); put(11, K_END, 1'b1);
    for (int i = 12; i < 16; i++) put(i, K_PAD, 1'b1);
    step(); chk("R3 R5 x16 end lane 11 with PAD", 1'b0, 6'b000000);
    restart(2'd1);
    open_pkt();
    fill(8'h32, 1'b0); put(5, K_END, 1'b1); put(6, K_PAD, 1'b1); put(7, K_PAD, 1'b1); step();
    chk("R3 x8 end lane 5", 1'b1, 6'b000010);
  endtask

  task automatic t_order();
    restart(2'd0);
    open_pkt();
    open_pkt(); chk("R4 start inside packet", 1'b1, 6'b000100);
    restart(2'd0);
    fill(K_SKP, 1'b1); put(3, K_END, 1'b1); step();
    chk("R4 end with no packet", 1'b1, 6'b000100);
  endtask

  task automatic t_pad();
    restart(2'd1);
    fill(K_PAD, 1'b0); fill(K_PAD, 1'b1); step();
    chk("R5 PAD without end", 1'b1, 6'b001000);
  endtask

  task automatic t_comma();
    restart(2'd1);
    fill(K_SKP, 1'b1); for (int i = 0; i < 4; i++) put(i, K_COM, 1'b1); step();
    chk("R6 comma on half the lanes", 1'b1, 6'b010000);
    restart(2'd1);
    fill(K_COM, 1'b1); step(); chk("R6 comma on all lanes", 1'b0, 6'b000000);
    fill(K_SKP, 1'b1); step(); chk("R6 ordered set body", 1'b0, 6'b000000);
  endtask

  task automatic t_idle_mix();
    restart(2'd1);
    open_pkt();
    fill(8'h00, 1'b0); put(3, K_END, 1'b1); step();
    chk("R7 idle as filler after end", 1'b1, 6'b100000);
  endtask

  task automatic t_width();
    restart(2'd0);
    fill(8'h00, 1'b0);
    for (int i = 4; i < LANES; i++) put(i, (i % 2 == 0) ? K_COM : K_STP, 1'b1);
    step(); chk("R8 inactive lanes ignored", 1'b0, 6'b000000);
    restart(2'd3);
    fill(K_SKP, 1'b1); for (int i = 0; i < 8; i++) put(i, K_COM, 1'b1); step();
    chk("R8 code 3 keeps 16 lanes", 1'b1, 6'b010000);
    restart(2'd3);
    open_pkt();
    fill(8'h41, 1'b0); put(15, K_END, 1'b1); step(); chk("R8 code 3 end lane 15", 1'b0, 6'b000000);
  endtask

  task automatic t_sticky();
    restart(2'd1);
    fill(K_SKP, 1'b1); put(0, K_COM, 1'b1); step();
    chk("R9 pulse on offending cycle", 1'b1, 6'b010000);
    fill(8'h00, 1'b0); step();
    chk("R9 R10 pulse ends, sticky holds", 1'b0, 6'b010000);
    step(); chk("R10 sticky still held", 1'b0, 6'b010000);
    clr = 1'b1; step(); clr = 1'b0;
    chk("R10 clear", 1'b0, 6'b000000);
    fill(K_SKP, 1'b1); put(2, K_COM, 1'b1); step();
    fill(K_PAD, 1'b1); clr = 1'b1; step(); clr = 1'b0;
    chk("R10 clear with new violation", 1'b1, 6'b001000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fill(8'h00, 1'b0);
    t_reset();
    t_x4_legal();
    t_x4_bad();
    t_x8_starts();
    t_ends_wide();
    t_order();
    t_pad();
    t_comma();
    t_idle_mix();
    t_width();
    t_sticky();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule